// File: doc/BRIEF.md
# Interrupt Aggregation Unit with APB3 Register Access

This block gathers interrupt requests from two kinds of sources and presents them to software over an APB3 slave port. It accepts single-cycle event pulses from one group of sources and steady levels from a second group, and produces one combined request line per group.

Each event source has a sticky capture bit, which software clears by writing a one to it. Each event source also has a software injection bit for debug and an enable gate. The gate is a block bit, so a 1 suppresses the source, and every gate comes out of reset blocking. A read-only view shows the gated result. Level sources skip the capture and injection stages: their gated view is the live input ANDed with the inverted block bit.

The six registers occupy consecutive 32-bit words that start at a parameterised word index. The event group comes first, in the order capture, inject, block, view. The level group follows with block, then view.

Top module: `intr_agg_apb`

## Requirements
- R1: After reset, capture and inject registers read 0, both block registers read all ones over their used bits, both view registers read 0, and irq_pulse and irq_level are low.
- R2: Byte address (BASE_WORD+k)*4 selects, for k = 0..5: event capture, event inject, event block, event view, level block, level view. Any other address, including a misaligned one with paddr[1:0] != 0, reads as 0 and ignores writes. Register bits at or above the group width read 0. pready is always 1 and pslverr is always 0.
- R3: A write takes effect on the rising edge where psel, penable and pwrite are all high. Read data is valid during the access phase.
- R4: A high pulse_src[i] at a rising edge sets capture bit i. The bit stays set until software clears it.
- R5: Writing to the capture register clears each bit where the write data holds 1 and leaves bits where it holds 0 unchanged.
- R6: When a source pulse and a clearing write hit the same capture bit on the same edge, the bit ends up set.
- R7: The inject and block registers of the event group are read-write. A block bit of 1 suppresses its source.
- R8: Event view bit i equals (capture[i] OR inject[i]) AND NOT block[i]. Writes to either view register have no effect on any register.
- R9: irq_pulse is the OR of the event view bits. It is driven from registers only, so it reflects a pulse or a write from the rising edge that captures it onward.
- R10: Level view bit j equals level_src[j] AND NOT level block[j]. The level block register is read-write. irq_level is the OR of the level view bits and follows level_src combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never signals an error |
| pulse_src | input | N_PULSE | Event sources, one-cycle pulses |
| level_src | input | N_LEVEL | Level sources |
| irq_pulse | output | 1 | Combined event-group request |
| irq_level | output | 1 | Combined level-group request |

## Verification
Each register changes on the edge that captures the pulse or the write. A view read therefore returns the new value in the first access phase after that edge, and irq_pulse has already changed by the next falling edge. irq_level differs: it follows level_src within the same cycle. The bench drives every input on a falling edge and samples outputs one time unit after a falling edge, so each read and each irq sample falls between the edge that produced the result and the edge after it. The event group is swept over all 4096 combinations of capture, inject and block for four sources. The level group is swept over all 64 combinations of level and block for three sources.

// File: rtl/intr_agg_pkg.sv
package intr_agg_pkg;

    // Register selected by the current APB address
    typedef enum logic [2:0] {
        SEL_RAW   = 3'd0,
        SEL_FRC   = 3'd1,
        SEL_MSK   = 3'd2,
        SEL_STAT  = 3'd3,
        SEL_LMSK  = 3'd4,
        SEL_LSTAT = 3'd5,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    localparam int unsigned NUM_WORDS = 6;

endpackage

// File: rtl/intr_apb_decode.sv
module intr_apb_decode
    import intr_agg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BASE_WORD = 0
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output reg_sel_e          sel,
    output logic              wr_en
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    logic              aligned;

    assign word_idx = paddr[ADDR_W-1:2];
    assign aligned  = (paddr[1:0] == 2'b00);
    assign wr_en    = psel && penable && pwrite;

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            for (int k = 0; k < NUM_WORDS; k++) begin
                if (word_idx == WORD_W'(BASE_WORD + k)) begin
                    sel = reg_sel_e'(k[2:0]);
                end
            end
        end
    end

endmodule

// File: rtl/intr_pulse_bank.sv
module intr_pulse_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse_src,
    input  logic         wr_raw,
    input  logic         wr_frc,
    input  logic         wr_msk,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw_q,
    output logic [N-1:0] frc_q,
    output logic [N-1:0] msk_q,
    output logic [N-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] raw;
        logic [N-1:0] frc;
        logic [N-1:0] msk;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_raw) begin
            st_d.raw = st_q.raw & ~wdata;
        end
        // a source event overrides a same-cycle clear
        st_d.raw = st_d.raw | pulse_src;
        if (wr_frc) begin
            st_d.frc = wdata;
        end
        if (wr_msk) begin
            st_d.msk = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.raw <= '0;
            st_q.frc <= '0;
            st_q.msk <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw_q = st_q.raw;
    assign frc_q = st_q.frc;
    assign msk_q = st_q.msk;

    for (genvar i = 0; i < N; i++) begin : g_stat
        assign status[i] = (st_q.raw[i] | st_q.frc[i]) & ~st_q.msk[i];
    end

    assign irq = |status;

endmodule

// File: rtl/intr_level_bank.sv
module intr_level_bank #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_src,
    input  logic         wr_msk,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] msk_q,
    output logic [N-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] msk;
    } lvl_st_t;

    lvl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_msk) begin
            st_d.msk = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.msk <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign msk_q = st_q.msk;

    for (genvar j = 0; j < N; j++) begin : g_stat
        assign status[j] = level_src[j] & ~st_q.msk[j];
    end

    assign irq = |status;

endmodule

// File: rtl/intr_agg_apb.sv
module intr_agg_apb
    import intr_agg_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned N_PULSE   = 4,
    parameter int unsigned N_LEVEL   = 3,
    parameter int unsigned BASE_WORD = 0
) (
    input  logic               pclk,
    input  logic               presetn,
    input  logic               psel,
    input  logic               penable,
    input  logic               pwrite,
    input  logic [ADDR_W-1:0]  paddr,
    input  logic [DATA_W-1:0]  pwdata,
    output logic [DATA_W-1:0]  prdata,
    output logic               pready,
    output logic               pslverr,
    input  logic [N_PULSE-1:0] pulse_src,
    input  logic [N_LEVEL-1:0] level_src,
    output logic               irq_pulse,
    output logic               irq_level
);
    reg_sel_e           sel;
    logic               wr_en;
    logic [N_PULSE-1:0] raw_q, frc_q, msk_q, p_status;
    logic [N_LEVEL-1:0] lmsk_q, l_status;
    logic               unused_wdata;

    assign unused_wdata = ^pwdata;

    intr_apb_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_WORD (BASE_WORD)
    ) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .sel     (sel),
        .wr_en   (wr_en)
    );

    intr_pulse_bank #(.N(N_PULSE)) u_pulse (
        .clk       (pclk),
        .rst_n     (presetn),
        .pulse_src (pulse_src),
        .wr_raw    (wr_en && (sel == SEL_RAW)),
        .wr_frc    (wr_en && (sel == SEL_FRC)),
        .wr_msk    (wr_en && (sel == SEL_MSK)),
        .wdata     (pwdata[N_PULSE-1:0]),
        .raw_q     (raw_q),
        .frc_q     (frc_q),
        .msk_q     (msk_q),
        .status    (p_status),
        .irq       (irq_pulse)
    );

    intr_level_bank #(.N(N_LEVEL)) u_level (
        .clk       (pclk),
        .rst_n     (presetn),
        .level_src (level_src),
        .wr_msk    (wr_en && (sel == SEL_LMSK)),
        .wdata     (pwdata[N_LEVEL-1:0]),
        .msk_q     (lmsk_q),
        .status    (l_status),
        .irq       (irq_level)
    );

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            unique case (sel)
                SEL_RAW:   prdata[N_PULSE-1:0] = raw_q;
                SEL_FRC:   prdata[N_PULSE-1:0] = frc_q;
                SEL_MSK:   prdata[N_PULSE-1:0] = msk_q;
                SEL_STAT:  prdata[N_PULSE-1:0] = p_status;
                SEL_LMSK:  prdata[N_LEVEL-1:0] = lmsk_q;
                SEL_LSTAT: prdata[N_LEVEL-1:0] = l_status;
                default:   prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/intr_agg_chk.sv
module intr_agg_chk #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned N_PULSE   = 4,
    parameter int unsigned N_LEVEL   = 3,
    parameter int unsigned BASE_WORD = 0
) (
    input logic               pclk,
    input logic               presetn,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [N_PULSE-1:0] wlow,
    input logic [N_PULSE-1:0] pulse_src,
    input logic [N_LEVEL-1:0] level_src,
    input logic [N_PULSE-1:0] raw_q,
    input logic [N_PULSE-1:0] frc_q,
    input logic [N_PULSE-1:0] msk_q,
    input logic [N_LEVEL-1:0] lmsk_q,
    input logic               irq_pulse,
    input logic               irq_level
);
    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'((BASE_WORD + 0) * 4);
    localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'((BASE_WORD + 3) * 4);
    localparam logic [ADDR_W-1:0] A_LSTAT = ADDR_W'((BASE_WORD + 5) * 4);

    logic               acc_wr;
    logic [N_PULSE-1:0] clr_vec;

    assign acc_wr  = psel && penable && pwrite;
    assign clr_vec = (acc_wr && paddr == A_RAW) ? wlow : '0;

    // R4 R6: a sampled event always leaves its capture bit set
    assert_event_sets_R6: assert property (@(posedge pclk) disable iff (!presetn)
        (|pulse_src) |=> ((raw_q & $past(pulse_src)) == $past(pulse_src)));

    // R5: capture bits change only by an event or a write-one clear
    assert_w1c_only_R5: assert property (@(posedge pclk) disable iff (!presetn)
        1'b1 |=> (raw_q == (($past(raw_q) & ~$past(clr_vec)) | $past(pulse_src))));

    // R7: with every source blocked the event line is quiet
    assert_all_blocked_quiet_R7: assert property (@(posedge pclk) disable iff (!presetn)
        (msk_q == '1) |-> !irq_pulse);

    // R8: a write to a view register leaves inject and block untouched
    assert_view_write_ignored_R8: assert property (@(posedge pclk) disable iff (!presetn)
        (acc_wr && (paddr == A_PSTAT || paddr == A_LSTAT))
        |=> ($stable(frc_q) && $stable(msk_q) && $stable(lmsk_q)));

    // R9: the event line needs a captured or injected source
    assert_irq_needs_source_R9: assert property (@(posedge pclk) disable iff (!presetn)
        irq_pulse |-> ((raw_q | frc_q) != '0));

    // R10: the level line follows unblocked live levels
    assert_level_gated_R10: assert property (@(posedge pclk) disable iff (!presetn)
        ((level_src & ~lmsk_q) == '0) |-> !irq_level);

    assert_level_source_R10: assert property (@(posedge pclk) disable iff (!presetn)
        irq_level |-> (|level_src));

endmodule

bind intr_agg_apb intr_agg_chk #(
    .ADDR_W    (ADDR_W),
    .N_PULSE   (N_PULSE),
    .N_LEVEL   (N_LEVEL),
    .BASE_WORD (BASE_WORD)
) u_chk (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .wlow      (pwdata[N_PULSE-1:0]),
    .pulse_src (pulse_src),
    .level_src (level_src),
    .raw_q     (raw_q),
    .frc_q     (frc_q),
    .msk_q     (msk_q),
    .lmsk_q    (lmsk_q),
    .irq_pulse (irq_pulse),
    .irq_level (irq_level)
);

// File: tb/sim_intr_agg_apb.sv
`timescale 1ns/1ps
module sim_intr_agg_apb;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int NP     = 4;
    localparam int NL     = 3;
    localparam int BASE   = 4;

    localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'((BASE + 0) * 4);
    localparam logic [ADDR_W-1:0] A_FRC   = ADDR_W'((BASE + 1) * 4);
    localparam logic [ADDR_W-1:0] A_MSK   = ADDR_W'((BASE + 2) * 4);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'((BASE + 3) * 4);
    localparam logic [ADDR_W-1:0] A_LMSK  = ADDR_W'((BASE + 4) * 4);
    localparam logic [ADDR_W-1:0] A_LSTAT = ADDR_W'((BASE + 5) * 4);

    logic              pclk = 1'b0;
    logic              presetn = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              pready, pslverr;
    logic [NP-1:0]     pulse_src = '0;
    logic [NL-1:0]     level_src = '0;
    logic              irq_pulse, irq_level;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 pclk = ~pclk;

    intr_agg_apb #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_PULSE(NP), .N_LEVEL(NL), .BASE_WORD(BASE)
    ) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .pulse_src(pulse_src), .level_src(level_src),
        .irq_pulse(irq_pulse), .irq_level(irq_level)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] got,
                         input logic [DATA_W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        d = prdata;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse(input logic [NP-1:0] v);
        @(negedge pclk);
        pulse_src = v;
        @(negedge pclk);
        pulse_src = '0;
    endtask

    initial begin
        repeat (190000) @(posedge pclk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] rd;
        logic [NP-1:0] expv;
        logic [NL-1:0] lexp;

        repeat (3) @(negedge pclk);
        presetn = 1'b1;

        // R1 reset values
        #1;
        check("R1 irq_pulse", 32'(irq_pulse), 0);
        check("R1 irq_level", 32'(irq_level), 0);
        apb_read(A_RAW, rd);   check("R1 raw", rd, 0);
        apb_read(A_FRC, rd);   check("R1 inject", rd, 0);
        apb_read(A_MSK, rd);   check("R1 block", rd, 32'hF);
        apb_read(A_STAT, rd);  check("R1 view", rd, 0);
        apb_read(A_LMSK, rd);  check("R1 level block", rd, 32'h7);
        apb_read(A_LSTAT, rd); check("R1 level view", rd, 0);
        check("R2 pready", 32'(pready), 1);
        check("R2 pslverr", 32'(pslverr), 0);

        // R4 each source alone, blocked, is captured but not signalled
        for (int i = 0; i < NP; i++) begin
            pulse(NP'(1 << i));
            apb_read(A_RAW, rd);  check("R4 capture single", rd, 32'(1 << i));
            apb_read(A_STAT, rd); check("R7 blocked view", rd, 0);
            check("R7 blocked irq", 32'(irq_pulse), 0);
            apb_write(A_RAW, 32'hF);
        end

        // R5 partial clear
        pulse(4'hF);
        apb_write(A_RAW, 32'h5);
        apb_read(A_RAW, rd); check("R5 partial clear", rd, 32'hA);
        apb_write(A_RAW, 32'h0);
        apb_read(A_RAW, rd); check("R5 zero write", rd, 32'hA);

        // R6 same-edge event and clear on bit 1; bit 3 cleared
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = A_RAW; pwdata = 32'hA;
        @(negedge pclk);
        penable = 1'b1; pulse_src = 4'h2;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; pulse_src = '0;
        apb_read(A_RAW, rd); check("R6 set wins", rd, 32'h2);
        apb_write(A_RAW, 32'hF);

        // R9 timing: unblock, pulse, irq up by the next falling edge
        apb_write(A_MSK, 32'h0);
        #1;
        check("R9 idle irq", 32'(irq_pulse), 0);
        pulse(4'h4);
        #1;
        check("R9 irq after event", 32'(irq_pulse), 1);
        apb_write(A_RAW, 32'h4);
        #1;
        check("R9 irq after clear", 32'(irq_pulse), 0);

        // R2 upper bits, misaligned and unmapped addresses
        apb_write(A_FRC, 32'hFFFF_FFFF);
        apb_read(A_FRC, rd); check("R2 upper bits zero", rd, 32'hF);
        apb_write(A_FRC, 32'h0);
        apb_write(A_FRC + 1, 32'h3);
        apb_read(A_FRC, rd); check("R2 misaligned write ignored", rd, 0);
        apb_write(A_MSK, 32'h9);
        apb_read(A_MSK + 2, rd); check("R2 misaligned read zero", rd, 0);
        apb_read(A_LSTAT + 4, rd); check("R2 unmapped read zero", rd, 0);
        apb_read(A_RAW - 4, rd); check("R2 below base read zero", rd, 0);

        // R8 view writes ignored
        apb_write(A_FRC, 32'h6);
        apb_write(A_STAT, 32'hF);
        apb_write(A_LSTAT, 32'h7);
        apb_read(A_FRC, rd);  check("R8 inject kept", rd, 32'h6);
        apb_read(A_MSK, rd);  check("R8 block kept", rd, 32'h9);
        apb_read(A_RAW, rd);  check("R8 capture kept", rd, 0);
        apb_read(A_LMSK, rd); check("R8 level block kept", rd, 32'h7);
        apb_read(A_STAT, rd); check("R8 view value", rd, 32'h6);

        // R7 R8 R9 exhaustive over capture, inject, block
        for (int r = 0; r < 16; r++) begin
            for (int f = 0; f < 16; f++) begin
                for (int m = 0; m < 16; m++) begin
                    apb_write(A_RAW, 32'hF);
                    pulse(NP'(r));
                    apb_write(A_FRC, 32'(f));
                    apb_write(A_MSK, 32'(m));
                    expv = NP'((r | f) & ~m);
                    apb_read(A_STAT, rd);
                    check("R8 view sweep", rd, 32'(expv));
                    check("R9 irq sweep", 32'(irq_pulse), 32'(|expv));
                end
            end
        end
        apb_read(A_FRC, rd); check("R7 inject readback", rd, 32'hF);
        apb_read(A_MSK, rd); check("R7 block readback", rd, 32'hF);

        // R10 exhaustive over level and level block
        for (int l = 0; l < 8; l++) begin
            for (int m = 0; m < 8; m++) begin
                apb_write(A_LMSK, 32'(m));
                @(negedge pclk);
                level_src = NL'(l);
                lexp = NL'(l & ~m);
                #1;
                check("R10 irq_level", 32'(irq_level), 32'(|lexp));
                apb_read(A_LSTAT, rd);
                check("R10 level view", rd, 32'(lexp));
            end
        end
        apb_read(A_LMSK, rd); check("R10 level block readback", rd, 32'h7);

        // R3 write without access phase has no effect
        @(negedge pclk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = A_FRC; pwdata = 32'h0;
        @(negedge pclk);
        psel = 1'b0; pwrite = 1'b0;
        apb_read(A_FRC, rd); check("R3 setup only ignored", rd, 32'hF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule